// File: doc/BRIEF.md
# DMA Transaction Splitter with Outstanding Limit

The block takes whole DMA read or write requests, each given as a start address, a byte count and a direction, and cuts each request into bus sub-transactions. A sub-transaction always stops at the earliest of four points: the next 4096-byte page edge, the next 16-byte line edge when its start is not on a 16-byte line, the maximum burst size, or the end of the request. The pieces go out in address order on a valid/ready output, one piece per handshake.

Every piece issued counts once toward an outstanding total, and a one-cycle completion pulse removes one from that total. The splitter does not offer a piece while the total sits at the cap, so the queue downstream can never hold more pieces than it has room for. The request is acknowledged in the same cycle as its final piece, so the source sees one handshake for each request, however many pieces the request becomes.

Top module: `dma_splitter`

## Requirements
- R1: No piece crosses a 4096-byte boundary: (subAddr mod 4096) + subLen <= 4096.
- R2: A piece whose start has nonzero low 4 bits ends no later than the next 16-byte boundary: subLen <= 16 - (subAddr mod 16).
- R3: Every piece has 1 <= subLen <= MAX_BURST (default 256). Its length is the smallest of the page room, the line room (only when misaligned), MAX_BURST and the remaining bytes. Pieces are issued in address order, each starting where the previous one ended, and they cover the request exactly.
- R4: The outstanding count never exceeds MAX_OUT (default 17), and subValid is low while the count equals MAX_OUT.
- R5: The outstanding count rises by one for each piece handshake and falls by one for each completion pulse. When a piece handshake and a completion fall in the same cycle, the count does not change.
- R6: A completion pulse with a zero count and no handshake in that cycle leaves the count at zero and sets errSticky. errSticky then stays high until reset.
- R7: A request with a length of zero is acknowledged without issuing any piece.
- R8: reqReady is high only in the cycle of the last piece's handshake, or in the acknowledge cycle of a zero-length request. subWrite repeats the direction of the request.
- R9: After reset, outstanding is 0 and errSticky, subValid and reqReady are low.
- R10: While subValid is high and subReady is low, subValid stays high and subAddr, subLen and subWrite hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Request acknowledged (last piece issued or zero length) |
| reqAddr | input | 32 | Request start byte address |
| reqLen | input | 16 | Request byte count |
| reqWrite | input | 1 | 1 = write, 0 = read |
| subValid | output | 1 | A piece is offered |
| subReady | input | 1 | Downstream takes the piece |
| subAddr | output | 32 | Piece start address |
| subLen | output | 16 | Piece byte count |
| subWrite | output | 1 | Piece direction |
| cplPulse | input | 1 | One piece has completed |
| outstanding | output | 5 | Pieces issued and not yet completed |
| errSticky | output | 1 | A completion arrived with nothing outstanding |

## Verification
The hardest state to reach is a count held at the cap, with a completion that comes in the same cycle as a new issue. The count reaches the cap only when completions are held back while one long request produces more than 17 pieces. The bench sends a 5 KB request from a page-aligned address with completions held back, and it keeps the stall going for several cycles. It then releases completions one cycle at a time while the output stays ready, so one completion frees the slot and the next one falls on the cycle of the following issue. The sweep around page edges and line offsets then runs with irregular ready and completion patterns.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef struct packed {
    logic loadReq;
    logic issuePiece;
  } ctlStrobes_t;
endpackage

// File: rtl/split_datapath.sv
module split_datapath
  import dma_split_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int ALIGN_BYTES = 16,
  parameter int MAX_BURST   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  pieceLen,
  output logic              curWrite,
  output logic              remZero,
  output logic              lastPiece
);
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES);
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);

  logic [LEN_W-1:0] remLen;
  logic [LEN_W-1:0] toPage;
  logic [LEN_W-1:0] toAlign;
  logic [LEN_W-1:0] capA;
  logic [LEN_W-1:0] capB;
  logic [PAGE_BITS-1:0]  pageOff;
  logic [ALIGN_BITS-1:0] lineOff;

  assign pageOff = curAddr[PAGE_BITS-1:0];
  assign lineOff = curAddr[ALIGN_BITS-1:0];

  always_comb begin
    toPage = LEN_W'(PAGE_BYTES) - LEN_W'(pageOff);
    if (lineOff != '0) toAlign = LEN_W'(ALIGN_BYTES) - LEN_W'(lineOff);
    else               toAlign = LEN_W'(MAX_BURST);
    capA = (toPage < toAlign) ? toPage : toAlign;
    capB = (capA < LEN_W'(MAX_BURST)) ? capA : LEN_W'(MAX_BURST);
    pieceLen = (remLen < capB) ? remLen : capB;
  end

  assign remZero   = (remLen == '0);
  assign lastPiece = (pieceLen == remLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLen   <= '0;
      curWrite <= 1'b0;
    end else if (strobes.loadReq) begin
      curAddr  <= reqAddr;
      remLen   <= reqLen;
      curWrite <= reqWrite;
    end else if (strobes.issuePiece) begin
      curAddr  <= curAddr + ADDR_W'(pieceLen);
      remLen   <= remLen - pieceLen;
    end
  end
endmodule

// File: rtl/split_control.sv
module split_control
  import dma_split_pkg::*;
#(
  parameter int MAX_OUT = 17,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             subReady,
  input  logic             cplPulse,
  input  logic             remZero,
  input  logic             lastPiece,
  output ctlStrobes_t      strobes,
  output logic             subValid,
  output logic             reqReady,
  output logic [CNT_W-1:0] count,
  output logic             errSticky
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;
  logic issue;

  assign subValid = (state == ST_BUSY) && !remZero && (count < CNT_W'(MAX_OUT));
  assign issue    = subValid && subReady;
  assign reqReady = (state == ST_BUSY) && (remZero || (issue && lastPiece));

  always_comb begin
    strobes.loadReq    = (state == ST_IDLE) && reqValid;
    strobes.issuePiece = issue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) state <= ST_BUSY;
        ST_BUSY: if (reqReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      errSticky <= 1'b0;
    end else begin
      if (issue && !cplPulse) begin
        count <= count + 1'b1;
      end else if (cplPulse && !issue) begin
        if (count != '0) count <= count - 1'b1;
        else             errSticky <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_splitter.sv
module dma_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int ALIGN_BYTES = 16,
  parameter int MAX_BURST   = 256,
  parameter int MAX_OUT     = 17,
  localparam int CNT_W      = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  output logic              subValid,
  input  logic              subReady,
  output logic [ADDR_W-1:0] subAddr,
  output logic [LEN_W-1:0]  subLen,
  output logic              subWrite,
  input  logic              cplPulse,
  output logic [CNT_W-1:0]  outstanding,
  output logic              errSticky
);
  ctlStrobes_t strobes;
  logic remZero;
  logic lastPiece;

  split_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .ALIGN_BYTES(ALIGN_BYTES), .MAX_BURST(MAX_BURST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite),
    .curAddr(subAddr), .pieceLen(subLen), .curWrite(subWrite),
    .remZero(remZero), .lastPiece(lastPiece)
  );

  split_control #(.MAX_OUT(MAX_OUT)) ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .subReady(subReady),
    .cplPulse(cplPulse), .remZero(remZero), .lastPiece(lastPiece),
    .strobes(strobes), .subValid(subValid), .reqReady(reqReady),
    .count(outstanding), .errSticky(errSticky)
  );
endmodule

// File: rtl/dma_splitter_chk.sv
module dma_splitter_chk #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 4096,
  parameter int ALIGN_BYTES = 16,
  parameter int MAX_BURST   = 256,
  parameter int MAX_OUT     = 17,
  localparam int CNT_W      = $clog2(MAX_OUT + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              subValid,
  input logic              subReady,
  input logic [ADDR_W-1:0] subAddr,
  input logic [LEN_W-1:0]  subLen,
  input logic              subWrite,
  input logic              cplPulse,
  input logic [CNT_W-1:0]  outstanding,
  input logic              errSticky
);
  localparam int PAGE_BITS  = $clog2(PAGE_BYTES);
  localparam int ALIGN_BITS = $clog2(ALIGN_BYTES);

  logic [31:0] pageEnd;
  logic [31:0] lineEnd;
  assign pageEnd = 32'(subAddr[PAGE_BITS-1:0]) + 32'(subLen);
  assign lineEnd = 32'(subAddr[ALIGN_BITS-1:0]) + 32'(subLen);

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> pageEnd <= 32'(PAGE_BYTES)); // R1
  AST_LINE_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subAddr[ALIGN_BITS-1:0] != '0) |-> lineEnd <= 32'(ALIGN_BYTES)); // R2
  AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> (subLen != '0 && 32'(subLen) <= 32'(MAX_BURST))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    32'(outstanding) <= 32'(MAX_OUT)); // R4
  AST_STALL_AT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (32'(outstanding) == 32'(MAX_OUT)) |-> !subValid); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subReady && cplPulse) |=> $stable(outstanding)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky); // R6
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !subReady) |=> (subValid && $stable(subAddr) && $stable(subLen) && $stable(subWrite))); // R10
endmodule

bind dma_splitter dma_splitter_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
  .ALIGN_BYTES(ALIGN_BYTES), .MAX_BURST(MAX_BURST), .MAX_OUT(MAX_OUT)
) chk_i (
  .clk(clk), .rstN(rstN), .subValid(subValid), .subReady(subReady),
  .subAddr(subAddr), .subLen(subLen), .subWrite(subWrite),
  .cplPulse(cplPulse), .outstanding(outstanding), .errSticky(errSticky)
);

// File: tb/dma_splitter_tb_top.sv
module dma_splitter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, subReady = 1'b0, cplPulse = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic reqReady, subValid, subWrite, errSticky;
  logic [31:0] subAddr;
  logic [15:0] subLen;
  logic [4:0]  outstanding;

  int checks = 0, fails = 0, cycles = 0;
  longint mA, mRem;
  logic mWr;
  int expCount = 0;
  logic expErr = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic heldV = 1'b0;
  logic [31:0] heldA;
  logic [15:0] heldL;
  int stallSeen = 0, bothSeen = 0;

  always #5 clk = ~clk;

  dma_splitter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite),
    .subValid(subValid), .subReady(subReady), .subAddr(subAddr),
    .subLen(subLen), .subWrite(subWrite), .cplPulse(cplPulse),
    .outstanding(outstanding), .errSticky(errSticky)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expPiece(input longint a, input longint r);
    longint m;
    m = 4096 - (a % 4096);
    if ((a % 16) != 0 && (16 - (a % 16)) < m) m = 16 - (a % 16);
    if (256 < m) m = 256;
    if (r < m) m = r;
    return m;
  endfunction

  // one cycle: drive at negedge, sample, update model, advance to next negedge
  task automatic step(input logic rdy, input logic cpl, output bit acked);
    bit hs;
    subReady = rdy;
    cplPulse = cpl;
    #1;
    acked = 1'b0;
    chk(outstanding == 5'(expCount), "R5 count", outstanding, expCount);
    chk(errSticky == expErr, "R6 error flag", errSticky, expErr);
    if (expCount == 17) begin
      chk(!subValid, "R4 stall at cap", subValid, 0);
      stallSeen++;
    end
    if (heldV) begin
      chk(subValid && subAddr == heldA && subLen == heldL, "R10 held offer", subAddr, heldA);
    end
    heldV = subValid && !rdy;
    heldA = subAddr;
    heldL = subLen;
    hs = subValid && rdy;
    if (hs) begin
      longint e;
      e = expPiece(mA, mRem);
      chk(longint'(subAddr) == mA, "R3 piece address", subAddr, mA);
      chk(longint'(subLen) == e, "R1 R2 R3 piece length", subLen, e);
      chk(subWrite == mWr, "R8 direction", subWrite, mWr);
      mA = mA + e;
      mRem = mRem - e;
    end
    if (reqReady) begin
      chk(mRem == 0, "R8 ack only at last piece", mRem, 0);
      acked = 1'b1;
    end
    if (hs && cpl) bothSeen++;
    else if (hs) expCount++;
    else if (cpl) begin
      if (expCount > 0) expCount--;
      else expErr = 1'b1;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  task automatic runReq(input longint a, input longint len, input logic wr, input int holdN);
    bit acked;
    int n;
    reqAddr = 32'(a); reqLen = 16'(len); reqWrite = wr; reqValid = 1'b1;
    mA = a; mRem = len; mWr = wr;
    n = 0;
    acked = 1'b0;
    while (!acked) begin
      if (n < holdN)           step(1'b1, 1'b0, acked);
      else if (n < holdN + 4)  step(1'b1, expCount > 0, acked);
      else                     step(lfsr[0] | lfsr[1], (expCount > 0) & lfsr[2], acked);
      n++;
    end
    reqValid = 1'b0;
  endtask

  initial begin
    bit acked;
    repeat (3) @(negedge clk);
    #1;
    chk(outstanding == 0 && !errSticky && !subValid && !reqReady, "R9 reset state",
        {outstanding, errSticky, subValid, reqReady}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: zero length accepted without pieces
    runReq(32'h2003, 0, 1'b0, 0);
    chk(mRem == 0 && mA == 32'h2003, "R7 zero length issued nothing", mA, 32'h2003);

    // R4 R5: long request with completions withheld
    runReq(32'h0, 5120, 1'b1, 25);
    chk(stallSeen > 0, "R4 stall reached", stallSeen, 1);
    chk(bothSeen > 0, "R5 simultaneous issue and completion", bothSeen, 1);

    // R1 R2 R3 sweep: line offsets x page-edge bases x lengths
    for (int b = 0; b < 4; b++) begin
      for (int off = 0; off < 16; off++) begin
        for (int li = 0; li < 10; li++) begin
          longint base, len;
          case (b)
            0: base = 32'h1000;
            1: base = 32'h2F00;
            2: base = 32'h3FF0;
            default: base = 32'h4FE0;
          endcase
          case (li)
            0: len = 0;    1: len = 1;    2: len = 15;  3: len = 16;  4: len = 17;
            5: len = 255;  6: len = 256;  7: len = 257; 8: len = 300; default: len = 1000;
          endcase
          runReq(base + off, len, 1'((b + off + li) & 1), 0);
        end
      end
    end

    // drain, then R6 spurious completion
    while (expCount > 0) step(1'b0, 1'b1, acked);
    step(1'b0, 1'b0, acked);
    chk(!errSticky, "R6 clean before spurious completion", errSticky, 0);
    step(1'b0, 1'b1, acked);
    step(1'b0, 1'b0, acked);
    chk(errSticky && outstanding == 0, "R6 flag set, count held at zero", errSticky, 1);
    repeat (3) step(1'b0, 1'b0, acked);
    chk(errSticky, "R6 flag stays", errSticky, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule